// File: doc/BRIEF.md
# Shadow RAM Segment Router

This block sits in the memory path of a PC-style chipset and steers each access to the upper option-ROM and BIOS window, C0000h through FFFFFh. The access goes either to on-board DRAM, where a shadow copy of the ROM may live, or out to the expansion bus where the real ROM answers. The window is cut into eight 32 KB segments, and each segment can be shadowed on its own.

Two global policy bits set what shadowing means for the segments that are enabled. One bit sends reads to DRAM and the other sends writes to DRAM. Firmware can therefore copy a ROM into DRAM while reads still come from the ROM, and then switch reads over to DRAM and protect the copy against writes.

The control bits sit in a small register bank that loads on a strobe. Routing itself is combinational from the address and the direction, so a decision is ready in the same cycle as the access. The block also gives two status flags that report whether the main BIOS segment is shadowed for reading and for writing.

Top module: `shadow_seg_router`

## Requirements
- R1: After reset the segment mask and both policy bits are zero, so every access inside the window goes to the external bus and both BIOS flags are low.
- R2: The mask and the policy bits take the configuration inputs only at a rising clock edge where `cfg_load` is high. At other edges, changes on those inputs have no effect on routing or on the flags.
- R3: An address A in the window belongs to segment (A - C0000h) >> 15, so segment i covers C0000h + i*8000h through C0000h + i*8000h + 7FFFh. Bit i of the mask controls segment i.
- R4: A read (`acc_write` = 0) to an enabled segment goes to DRAM (`route_int` high) when the read policy bit is 1. It goes to the bus (`route_ext` high) when that bit is 0.
- R5: A write (`acc_write` = 1) to an enabled segment goes to DRAM when the write policy bit is 1. It goes to the bus when that bit is 0.
- R6: Any access to a segment whose mask bit is 0 goes to the bus, whatever the policy bits are.
- R7: Addresses below C0000h are not claimed: `route_int` and `route_ext` are both low.
- R8: For every claimed address, exactly one of `route_int` and `route_ext` is high. The two are never high together.
- R9: `bios_rd_shadow` is high exactly when mask bit 6 (segment F0000h-F7FFFh) and the read policy bit are both set.
- R10: `bios_wr_shadow` is high exactly when mask bit 6 and the write policy bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Loads the configuration inputs at the next rising edge |
| cfg_seg_en | input | 8 | Per-segment shadow enable, bit i for segment i |
| cfg_rd_int | input | 1 | Read policy: 1 sends reads of enabled segments to DRAM |
| cfg_wr_int | input | 1 | Write policy: 1 sends writes of enabled segments to DRAM |
| acc_addr | input | 20 | Byte address of the current access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| route_int | output | 1 | The access is served by internal DRAM |
| route_ext | output | 1 | The access is sent to the external bus |
| bios_rd_shadow | output | 1 | The BIOS segment is shadowed for reads |
| bios_wr_shadow | output | 1 | The BIOS segment is shadowed for writes |

## Verification
The assertions check on every cycle that the two routing outputs never fire together, and that an unclaimed address leaves both low. They also check that a disabled segment always goes to the bus, that the registered controls move only after a load, and that the BIOS flags agree with the routing of accesses to segment 6. The bench's scenarios are needed to show the segment boundaries, which segment each address falls in, the exact read and write policy under several masks, and the reset state. Only the scenarios can show that configuration changes made without a load are ignored when the routing is observed at the ports.

// File: rtl/shadow_rt_pkg.sv
package shadow_rt_pkg;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_EXT  = 2'b01,
    ROUTE_INT  = 2'b10
  } route_e;

  function automatic route_e pick_route(input logic claimed, input logic go_int);
    if (!claimed)    return ROUTE_NONE;
    else if (go_int) return ROUTE_INT;
    else             return ROUTE_EXT;
  endfunction

endpackage

// File: rtl/shadow_ctrl_regs.sv
module shadow_ctrl_regs #(
  parameter int unsigned SEG_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEG_N-1:0] seg_en_d,
  input  logic             rd_int_d,
  input  logic             wr_int_d,
  output logic [SEG_N-1:0] seg_en_q,
  output logic             rd_int_q,
  output logic             wr_int_q
);

  logic [SEG_N-1:0] seg_en_nx;
  logic             rd_int_nx;
  logic             wr_int_nx;

  always_comb begin
    seg_en_nx = seg_en_q;
    rd_int_nx = rd_int_q;
    wr_int_nx = wr_int_q;
    if (load) begin
      seg_en_nx = seg_en_d;
      rd_int_nx = rd_int_d;
      wr_int_nx = wr_int_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_en_q <= '0;
      rd_int_q <= 1'b0;
      wr_int_q <= 1'b0;
    end else begin
      seg_en_q <= seg_en_nx;
      rd_int_q <= rd_int_nx;
      wr_int_q <= wr_int_nx;
    end
  end

  // R2: no load, no change
  a_r2_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(seg_en_q) && $stable(rd_int_q) && $stable(wr_int_q)));

  // R2: a load captures the inputs
  a_r2_capture_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (seg_en_q == $past(seg_en_d) && rd_int_q == $past(rd_int_d)
              && wr_int_q == $past(wr_int_d)));

endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned SEG_N    = 8,
  parameter int unsigned SEG_LOG2 = 15,
  parameter logic [ADDR_W-1:0] BASE = 20'hC0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              claimed,
  output logic [SEG_N-1:0]  seg_hit
);

  localparam int unsigned IDX_W = (SEG_N > 1) ? $clog2(SEG_N) : 1;
  localparam logic [ADDR_W:0] SPAN   = (ADDR_W+1)'(SEG_N) << SEG_LOG2;
  localparam logic [ADDR_W:0] LIMIT  = {1'b0, BASE} + SPAN;

  logic [ADDR_W-1:0] offset;
  logic [IDX_W-1:0]  seg_idx;

  always_comb begin
    claimed = ({1'b0, addr} >= {1'b0, BASE}) && ({1'b0, addr} < LIMIT);
    offset  = addr - BASE;
    seg_idx = offset[SEG_LOG2 +: IDX_W];
  end

  for (genvar g = 0; g < SEG_N; g++) begin : g_hit
    assign seg_hit[g] = claimed && (seg_idx == IDX_W'(g));
  end

  // R3: a claimed address lands in exactly one segment
  a_r3_single_segment: assert property (@(posedge clk) disable iff (!rst_n)
    claimed |-> $countones(seg_hit) == 1);

  // R7: nothing outside the window hits a segment
  a_r7_no_hit_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !claimed |-> seg_hit == '0);

endmodule

// File: rtl/shadow_route_sel.sv
module shadow_route_sel
  import shadow_rt_pkg::*;
#(
  parameter int unsigned SEG_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEG_N-1:0] seg_hit,
  input  logic [SEG_N-1:0] seg_en,
  input  logic             rd_int,
  input  logic             wr_int,
  input  logic             is_write,
  output route_e           route
);

  logic             policy;
  logic [SEG_N-1:0] seg_int;

  assign policy = is_write ? wr_int : rd_int;

  for (genvar g = 0; g < SEG_N; g++) begin : g_seg
    assign seg_int[g] = seg_hit[g] & seg_en[g] & policy;
  end

  always_comb route = pick_route(|seg_hit, |seg_int);

  // R6: a disabled segment always goes to the bus
  a_r6_disabled_external: assert property (@(posedge clk) disable iff (!rst_n)
    (|(seg_hit & ~seg_en)) |-> route == ROUTE_EXT);

  // R8: a claimed access never goes unrouted
  a_r8_claimed_routed: assert property (@(posedge clk) disable iff (!rst_n)
    (|seg_hit) |-> route != ROUTE_NONE);

  // R4: reads go internal only under the read policy
  a_r4_read_policy: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_write && route == ROUTE_INT) |-> rd_int);

  // R5: writes go internal only under the write policy
  a_r5_write_policy: assert property (@(posedge clk) disable iff (!rst_n)
    (is_write && route == ROUTE_INT) |-> wr_int);

endmodule

// File: rtl/shadow_seg_router.sv
module shadow_seg_router
  import shadow_rt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned SEG_N    = 8,
  parameter int unsigned SEG_LOG2 = 15,
  parameter int unsigned BIOS_SEG = 6,
  parameter logic [ADDR_W-1:0] BASE = 20'hC0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [SEG_N-1:0]  cfg_seg_en,
  input  logic              cfg_rd_int,
  input  logic              cfg_wr_int,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              route_int,
  output logic              route_ext,
  output logic              bios_rd_shadow,
  output logic              bios_wr_shadow
);

  logic [SEG_N-1:0] seg_en_q;
  logic             rd_int_q;
  logic             wr_int_q;
  logic             claimed;
  logic [SEG_N-1:0] seg_hit;
  route_e           route;

  shadow_ctrl_regs #(.SEG_N(SEG_N)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .seg_en_d (cfg_seg_en),
    .rd_int_d (cfg_rd_int),
    .wr_int_d (cfg_wr_int),
    .seg_en_q (seg_en_q),
    .rd_int_q (rd_int_q),
    .wr_int_q (wr_int_q)
  );

  shadow_seg_decode #(
    .ADDR_W(ADDR_W), .SEG_N(SEG_N), .SEG_LOG2(SEG_LOG2), .BASE(BASE)
  ) i_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (acc_addr),
    .claimed (claimed),
    .seg_hit (seg_hit)
  );

  shadow_route_sel #(.SEG_N(SEG_N)) i_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .seg_hit  (seg_hit),
    .seg_en   (seg_en_q),
    .rd_int   (rd_int_q),
    .wr_int   (wr_int_q),
    .is_write (acc_write),
    .route    (route)
  );

  always_comb begin
    route_int      = (route == ROUTE_INT);
    route_ext      = (route == ROUTE_EXT);
    bios_rd_shadow = seg_en_q[BIOS_SEG] & rd_int_q;
    bios_wr_shadow = seg_en_q[BIOS_SEG] & wr_int_q;
  end

  // R8: the two routing outputs are exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(route_int && route_ext));

  // R7: unclaimed addresses drive nothing
  a_r7_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !claimed |-> (!route_int && !route_ext));

  // R9: read flag agrees with routing of BIOS-segment reads
  a_r9_bios_read: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_hit[BIOS_SEG] && !acc_write) |-> (route_int == bios_rd_shadow));

  // R10: write flag agrees with routing of BIOS-segment writes
  a_r10_bios_write: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_hit[BIOS_SEG] && acc_write) |-> (route_int == bios_wr_shadow));

endmodule

// File: tb/test_shadow_seg_router.sv
module test_shadow_seg_router;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  e_int;
    logic  e_ext;
    logic  e_bfr;
    logic  e_bfw;
    string tag;
    logic [19:0] a;
    logic  w;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [7:0]  cfg_seg_en;
  logic        cfg_rd_int;
  logic        cfg_wr_int;
  logic [19:0] acc_addr;
  logic        acc_write;
  logic        route_int, route_ext, bios_rd_shadow, bios_wr_shadow;

  item_t q[$];
  event  sample_ev;
  int    checks = 0;
  int    fails = 0;
  bit    done = 0;

  logic [7:0] m_mask = 8'h00;
  logic       m_rd = 1'b0;
  logic       m_wr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_seg_router i_shadow_seg_router (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_seg_en(cfg_seg_en),
    .cfg_rd_int(cfg_rd_int), .cfg_wr_int(cfg_wr_int), .acc_addr(acc_addr),
    .acc_write(acc_write), .route_int(route_int), .route_ext(route_ext),
    .bios_rd_shadow(bios_rd_shadow), .bios_wr_shadow(bios_wr_shadow)
  );

  // Driver: applies an access and pushes the expected result
  task automatic drive(input logic [19:0] a, input logic w, input string tag);
    item_t it;
    logic claimed, en, go_int;
    int seg;
    @(negedge clk);
    acc_addr  = a;
    acc_write = w;
    claimed = (a >= 20'hC0000);
    seg     = int'((a - 20'hC0000) >> 15);
    en      = claimed && m_mask[seg[2:0]];
    go_int  = en && (w ? m_wr : m_rd);
    it.e_int = claimed && go_int;
    it.e_ext = claimed && !go_int;
    it.e_bfr = m_mask[6] && m_rd;
    it.e_bfw = m_mask[6] && m_wr;
    it.tag = tag; it.a = a; it.w = w;
    q.push_back(it);
    #(CLK_PERIOD/4);
    -> sample_ev;
    #1;
  endtask

  // Monitor: pops expected items and compares
  initial begin
    item_t it;
    forever begin
      @(sample_ev);
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (route_int !== it.e_int || route_ext !== it.e_ext ||
            bios_rd_shadow !== it.e_bfr || bios_wr_shadow !== it.e_bfw) begin
          fails++;
          $display("FAIL %s addr=%h w=%0b actual int/ext/bfr/bfw=%b%b%b%b expected=%b%b%b%b",
                   it.tag, it.a, it.w, route_int, route_ext, bios_rd_shadow,
                   bios_wr_shadow, it.e_int, it.e_ext, it.e_bfr, it.e_bfw);
        end
      end
    end
  end

  task automatic configure(input logic [7:0] m, input logic r, input logic w);
    @(negedge clk);
    cfg_seg_en = m; cfg_rd_int = r; cfg_wr_int = w; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_mask = m; m_rd = r; m_wr = w;
  endtask

  task automatic sweep();
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 2; d++) begin
        logic [19:0] a;
        string t;
        a = 20'hC0000 + 20'(s) * 20'h8000 + 20'h1234;
        if (!m_mask[s])  t = "R6";
        else if (d == 1) t = "R5";
        else             t = "R4";
        if (s == 6) t = (d == 1) ? "R10" : "R9";
        drive(a, d[0], t);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_seg_en = 8'h00;
    cfg_rd_int = 1'b0; cfg_wr_int = 1'b0; acc_addr = '0; acc_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    drive(20'hC0000, 1'b0, "R1");
    drive(20'hF8000, 1'b1, "R1");
    drive(20'hF4000, 1'b0, "R1");

    // R4 R5 R6: mixed mask, reads internal
    configure(8'b0100_0101, 1'b1, 1'b0);
    sweep();
    // writes internal
    configure(8'hFF, 1'b0, 1'b1);
    sweep();
    configure(8'hFF, 1'b1, 1'b1);
    sweep();
    configure(8'b1011_1010, 1'b1, 1'b1);
    sweep();

    // R3 boundaries and R7 outside
    configure(8'b0000_0010, 1'b1, 1'b1);
    drive(20'hBFFFF, 1'b0, "R7");
    drive(20'h00000, 1'b1, "R7");
    drive(20'h7FFFF, 1'b0, "R7");
    drive(20'hC7FFF, 1'b0, "R3");
    drive(20'hC8000, 1'b0, "R3");
    drive(20'hCFFFF, 1'b1, "R3");
    drive(20'hD0000, 1'b1, "R3");
    configure(8'b1000_0000, 1'b1, 1'b0);
    drive(20'hFFFFF, 1'b0, "R3");
    drive(20'hF7FFF, 1'b0, "R3");
    drive(20'hFFFFF, 1'b1, "R8");

    // R2: inputs change without load, routing keeps old state
    @(negedge clk);
    cfg_seg_en = 8'h00; cfg_rd_int = 1'b0; cfg_wr_int = 1'b1;
    repeat (3) @(negedge clk);
    drive(20'hF8010, 1'b0, "R2");
    drive(20'hF8010, 1'b1, "R2");
    @(negedge clk);
    cfg_seg_en = 8'hFF;
    repeat (2) @(negedge clk);
    drive(20'hF0000, 1'b0, "R2");

    // R9 R10: BIOS flags alone
    configure(8'b0100_0000, 1'b0, 1'b1);
    drive(20'hF0000, 1'b1, "R10");
    drive(20'hF0000, 1'b0, "R9");
    configure(8'b1011_1111, 1'b1, 1'b1);
    drive(20'hF3000, 1'b0, "R9");
    drive(20'hE0000, 1'b1, "R10");

    // R1: reset again clears the controls
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_mask = 8'h00; m_rd = 1'b0; m_wr = 1'b0;
    drive(20'hF0000, 1'b0, "R1");
    drive(20'hE8000, 1'b1, "R1");

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule